// File: doc/BRIEF.md
# Embedded Sync Code Decoder

This block sits on the parallel pixel input of a camera capture path. It finds timing markers that are carried inside the data stream instead of on separate sync wires. A marker is four valid words in a row. The first three are a fixed preamble: a word with every active bit set, then two words with every active bit clear. The fourth word says which timing event the marker stands for.

The decoder compares that fourth word with four programmed event values: frame begin, line begin, line finish and frame finish. Each comparison has its own unmask byte, and the position of the unmask window follows the selected pixel width. For each decoded event the block gives a one-cycle strobe. It also keeps frame and line window levels, and passes only the pixel words that arrive inside a line, tagged with a valid bit.

Three sticky flags record a malformed or unknown marker, a pixel accepted while the downstream FIFO was full, and a completed frame. A one-cycle write-one-to-clear pulse clears each flag. Two special settings exist. Programming the frame-finish value to 0xFF turns every unknown marker into a frame finish. Setting both the frame-begin value and its unmask to 0xFF makes the block infer frame begin from the first line begin after a frame finish.

Top module: `esync_decoder`

## Requirements
- R1: A marker is an all-ones word, then two all-zeros words, then a code word, all with `pix_valid_i` high. The all-ones and all-zeros tests use only the low 8+2*`width_sel_i` data bits and ignore the bits above them. Preamble words and code words never appear as pixel output.
- R2: The 8-bit code is taken from data bits [2*`width_sel_i`+7 : 2*`width_sel_i`]. The event values are packed in `code_cfg_i` as frame begin [7:0], line begin [15:8], line finish [23:16] and frame finish [31:24], and `unmask_cfg_i` uses the same packing. An event matches when every code bit whose unmask bit is 1 equals the programmed bit; a 0 unmask bit makes that code bit don't-care.
- R3: When several values match, only one strobe fires, chosen in the order frame begin, line begin, line finish, frame finish.
- R4: With frame-finish value 0xFF, a code that matches neither frame begin, line begin nor line finish is decoded as frame finish and raises no error.
- R5: With frame-begin value 0xFF and frame-begin unmask 0xFF, no code decodes as frame begin. The first line begin after reset or after a frame finish fires both `frame_start_o` and `line_start_o`. Later line begins fire only `line_start_o`.
- R6: Each event strobe is high for exactly the one cycle after the clock edge that accepts the code word.
- R7: `frame_valid_o` rises with a frame-begin strobe and falls with a frame-finish strobe. `line_valid_o` rises with a line-begin strobe and falls with a line-finish strobe.
- R8: A non-marker word accepted while `line_valid_o` is high appears on `pixel_data_o`, with `pixel_valid_o` high, in the next cycle. Words outside a line give no pixel.
- R9: `status_o[2]` is set when a preamble breaks off before its code word, and when a code matches no event while frame finish is not 0xFF. In either case no strobe fires.
- R10: `status_o[0]` is set when a frame finish is decoded while `frame_valid_o` is high.
- R11: `status_o[1]` is set when a pixel is accepted while `fifo_full_i` is high.
- R12: A 1 in bit k of `clear_i` clears `status_o[k]` after one edge. A 0 leaves the flag unchanged.
- R13: After reset all strobes, levels, pixel outputs and status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid_i | input | 1 | Input word valid |
| pix_data_i | input | DW | Input pixel or marker word |
| width_sel_i | input | 2 | Pixel width select: 0..3 for 8/10/12/14 bits |
| code_cfg_i | input | 32 | Programmed event code values |
| unmask_cfg_i | input | 32 | Per-event compare unmask bytes |
| fifo_full_i | input | 1 | Downstream pixel FIFO full |
| clear_i | input | 3 | Write-one-to-clear pulses for the status flags |
| frame_start_o | output | 1 | Frame begin strobe |
| line_start_o | output | 1 | Line begin strobe |
| line_end_o | output | 1 | Line finish strobe |
| frame_end_o | output | 1 | Frame finish strobe |
| frame_valid_o | output | 1 | Frame window level |
| line_valid_o | output | 1 | Line window level |
| pixel_valid_o | output | 1 | Output pixel valid |
| pixel_data_o | output | DW | Output pixel word |
| status_o | output | 3 | Sticky flags: [0] frame done, [1] overrun, [2] sync error |

## Verification
The bench checks the corners where a faulty decoder goes wrong without any visible fault on the common path:
- At a wider pixel width, junk in the bits above the active width must not break the preamble. The compare window must sit at the shifted position; a fixed window would lose the line begin.
- When frame begin and line begin carry the same value, a wrong priority would strobe the wrong event.
- A mask stuck in the wrong sense would fail to match a code whose don't-care bits differ from the programmed value.
- An unknown code must still decode under the frame-finish wildcard, and must raise the error flag without it.
- In inferred mode, the bench checks that frame begin fires only on the first line begin of a frame. A missing frame-gap flag would repeat it on every line.
- Clearing one flag must leave the others set.

// File: rtl/esync_pkg.sv
package esync_pkg;
  localparam int CODE_W = 8;
  localparam int N_EVT  = 4;
  localparam int N_STS  = 3;
  localparam int STS_DONE = 0;
  localparam int STS_OVR  = 1;
  localparam int STS_ERR  = 2;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_ONES  = 2'd1,
    PS_ZERO1 = 2'd2,
    PS_ZERO2 = 2'd3
  } pre_state_t;

  typedef struct packed {
    logic fs;
    logic ls;
    logic le;
    logic fe;
  } sync_evt_t;
endpackage

// File: rtl/esync_preamble.sv
module esync_preamble
  import esync_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_data,
  input  logic [1:0]        width_sel,
  output logic              code_hit,
  output logic              brk,
  output logic              pix_hit,
  output logic [CODE_W-1:0] code_word
);
  localparam int SEL_W = 2;

  pre_state_t    st_q, st_nx;
  logic [DW-1:0] act_mask;
  logic [DW-1:0] shifted;
  logic          all_ones, all_zero;

  always_comb begin
    for (int i = 0; i < DW; i++) begin
      act_mask[i] = (i < (CODE_W + 2 * int'(width_sel)));
    end
  end

  assign all_ones  = ((in_data & act_mask) == act_mask);
  assign all_zero  = ((in_data & act_mask) == '0);
  assign shifted   = in_data >> {width_sel, 1'b0};
  assign code_word = shifted[CODE_W-1:0];

  always_comb begin
    st_nx    = st_q;
    code_hit = 1'b0;
    brk      = 1'b0;
    pix_hit  = 1'b0;
    if (in_valid) begin
      unique case (st_q)
        PS_IDLE: begin
          if (all_ones) st_nx = PS_ONES;
          else          pix_hit = 1'b1;
        end
        PS_ONES: begin
          if (all_zero) st_nx = PS_ZERO1;
          else begin
            brk   = 1'b1;
            st_nx = PS_IDLE;
          end
        end
        PS_ZERO1: begin
          if (all_zero) st_nx = PS_ZERO2;
          else begin
            brk   = 1'b1;
            st_nx = PS_IDLE;
          end
        end
        PS_ZERO2: begin
          code_hit = 1'b1;
          st_nx    = PS_IDLE;
        end
        default: st_nx = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        st_q <= PS_IDLE;
    else if (in_valid) st_q <= st_nx;
  end

  // R1: after a code word the matcher is idle again
  assert_code_to_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    code_hit |=> (st_q == PS_IDLE));
  // R1: a pixel is only seen in idle, never mid-preamble
  assert_pix_only_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_hit |-> (st_q == PS_IDLE));
  // R1: at most one classification per accepted word
  assert_one_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({code_hit, brk, pix_hit}));
endmodule

// File: rtl/esync_match.sv
module esync_match
  import esync_pkg::*;
(
  input  logic [CODE_W-1:0]       code_word,
  input  logic [N_EVT*CODE_W-1:0] code_cfg,
  input  logic [N_EVT*CODE_W-1:0] unmask_cfg,
  input  logic                    frame_gap,
  output sync_evt_t               evt,
  output logic                    miss
);
  localparam logic [CODE_W-1:0] ALL_SET = '1;

  logic [N_EVT-1:0] hit;
  logic             infer_fs, wild_fe;

  for (genvar k = 0; k < N_EVT; k++) begin : g_cmp
    assign hit[k] = (((code_word ^ code_cfg[k*CODE_W +: CODE_W])
                      & unmask_cfg[k*CODE_W +: CODE_W]) == '0);
  end

  assign infer_fs = (code_cfg[CODE_W-1:0] == ALL_SET) &&
                    (unmask_cfg[CODE_W-1:0] == ALL_SET);
  assign wild_fe  = (code_cfg[N_EVT*CODE_W-1 -: CODE_W] == ALL_SET);

  always_comb begin
    evt  = '0;
    miss = 1'b0;
    if (hit[0] && !infer_fs) begin
      evt.fs = 1'b1;
    end else if (hit[1]) begin
      evt.ls = 1'b1;
      evt.fs = infer_fs && frame_gap;
    end else if (hit[2]) begin
      evt.le = 1'b1;
    end else if (hit[3] || wild_fe) begin
      evt.fe = 1'b1;
    end else begin
      miss = 1'b1;
    end
  end
endmodule

// File: rtl/esync_status.sv
module esync_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic flag_nx, flag_en;
    assign flag_en = set_i[k] | clr_i[k];
    assign flag_nx = set_i[k] | (flags_o[k] & ~clr_i[k]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flags_o[k] <= 1'b0;
      else if (flag_en) flags_o[k] <= flag_nx;
    end

    // R12: a flag without a clear pulse stays set
    assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[k] && !clr_i[k]) |=> flags_o[k]);
    // R12: a clear pulse without a new event empties the flag
    assert_flag_cleared_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[k] && !set_i[k]) |=> !flags_o[k]);
  end
endmodule

// File: rtl/esync_decoder.sv
module esync_decoder
  import esync_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pix_valid_i,
  input  logic [DW-1:0]           pix_data_i,
  input  logic [1:0]              width_sel_i,
  input  logic [N_EVT*CODE_W-1:0] code_cfg_i,
  input  logic [N_EVT*CODE_W-1:0] unmask_cfg_i,
  input  logic                    fifo_full_i,
  input  logic [N_STS-1:0]        clear_i,
  output logic                    frame_start_o,
  output logic                    line_start_o,
  output logic                    line_end_o,
  output logic                    frame_end_o,
  output logic                    frame_valid_o,
  output logic                    line_valid_o,
  output logic                    pixel_valid_o,
  output logic [DW-1:0]           pixel_data_o,
  output logic [N_STS-1:0]        status_o
);
  logic              code_hit, brk, pix_hit, miss;
  logic [CODE_W-1:0] code_word;
  sync_evt_t         m_evt, evt_nx, evt_q;
  logic              fv_q, fv_nx, lv_q, lv_nx, gap_q, gap_nx;
  logic              pv_q, pix_take;
  logic [DW-1:0]     pd_q;
  logic [N_STS-1:0]  sts_set;

  esync_preamble #(.DW(DW)) u_pre (
    .clk(clk), .rst_n(rst_n), .in_valid(pix_valid_i), .in_data(pix_data_i),
    .width_sel(width_sel_i), .code_hit(code_hit), .brk(brk),
    .pix_hit(pix_hit), .code_word(code_word)
  );

  esync_match u_match (
    .code_word(code_word), .code_cfg(code_cfg_i), .unmask_cfg(unmask_cfg_i),
    .frame_gap(gap_q), .evt(m_evt), .miss(miss)
  );

  always_comb begin
    evt_nx = (code_hit && !miss) ? m_evt : '0;
    fv_nx  = fv_q;
    lv_nx  = lv_q;
    gap_nx = gap_q;
    if (evt_nx.fs)      fv_nx = 1'b1;
    else if (evt_nx.fe) fv_nx = 1'b0;
    if (evt_nx.ls)      lv_nx = 1'b1;
    else if (evt_nx.le) lv_nx = 1'b0;
    if (evt_nx.fe)      gap_nx = 1'b1;
    else if (evt_nx.fs) gap_nx = 1'b0;
    pix_take = pix_hit && lv_q;
    sts_set           = '0;
    sts_set[STS_DONE] = evt_nx.fe && fv_q;
    sts_set[STS_OVR]  = pix_take && fifo_full_i;
    sts_set[STS_ERR]  = brk || (code_hit && miss);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      fv_q  <= 1'b0;
      lv_q  <= 1'b0;
      gap_q <= 1'b1;
      pv_q  <= 1'b0;
    end else begin
      evt_q <= evt_nx;
      fv_q  <= fv_nx;
      lv_q  <= lv_nx;
      gap_q <= gap_nx;
      pv_q  <= pix_take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pd_q <= '0;
    else if (pix_take) pd_q <= pix_data_i;
  end

  esync_status #(.N(N_STS)) u_sts (
    .clk(clk), .rst_n(rst_n), .set_i(sts_set), .clr_i(clear_i), .flags_o(status_o)
  );

  assign frame_start_o = evt_q.fs;
  assign line_start_o  = evt_q.ls;
  assign line_end_o    = evt_q.le;
  assign frame_end_o   = evt_q.fe;
  assign frame_valid_o = fv_q;
  assign line_valid_o  = lv_q;
  assign pixel_valid_o = pv_q;
  assign pixel_data_o  = pd_q;

  // R3: line begin, line finish and frame finish never strobe together
  assert_single_evt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({line_start_o, line_end_o, frame_end_o}));
  // R3: frame begin excludes the finishing events
  assert_fs_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> !(line_end_o || frame_end_o));
  // R7: frame window opens only with a frame begin strobe
  assert_fv_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_valid_o) |-> frame_start_o);
  // R7: line window closes only with a line finish strobe
  assert_lv_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_valid_o) |-> line_end_o);
  // R8: a pixel follows a cycle in which the line window was open
  assert_pix_in_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pixel_valid_o |-> $past(line_valid_o));
  // R9: a broken preamble raises the sync error flag
  assert_err_on_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> status_o[STS_ERR]);
endmodule

// File: tb/esync_decoder_test.sv
module esync_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_valid;
  logic [13:0] pix_data;
  logic [1:0]  wsel;
  logic [31:0] code_cfg, unmask_cfg;
  logic        fifo_full;
  logic [2:0]  clr;
  logic        fs, ls, le, fe, fv, lv, pv;
  logic [13:0] pd;
  logic [2:0]  sts;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  esync_decoder #(.DW(14)) uut (
    .clk(clk), .rst_n(rst_n), .pix_valid_i(pix_valid), .pix_data_i(pix_data),
    .width_sel_i(wsel), .code_cfg_i(code_cfg), .unmask_cfg_i(unmask_cfg),
    .fifo_full_i(fifo_full), .clear_i(clr),
    .frame_start_o(fs), .line_start_o(ls), .line_end_o(le), .frame_end_o(fe),
    .frame_valid_o(fv), .line_valid_o(lv), .pixel_valid_o(pv),
    .pixel_data_o(pd), .status_o(sts)
  );

  // row: {data[7:0], fs, ls, le, fe, fv, lv, pv}, each output seen one cycle later
  localparam int NV = 19;
  localparam logic [14:0] VEC [NV] = '{
    15'h7F80, 15'h0000, 15'h0000, 15'h08C4,
    15'h7F84, 15'h0004, 15'h0004, 15'h1126,
    15'h0287, 15'h0387,
    15'h7F86, 15'h0006, 15'h0006, 15'h1994,
    15'h0484,
    15'h7F84, 15'h0004, 15'h0004, 15'h2208
  };

  localparam logic [31:0] CFG_STD = 32'h4433_2211;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [13:0] w);
    pix_valid = 1'b1;
    pix_data  = w;
    @(negedge clk);
    pix_valid = 1'b0;
    pix_data  = '0;
  endtask

  task automatic put_code(input logic [7:0] c);
    put(14'h00FF);
    put(14'h0000);
    put(14'h0000);
    put({6'h00, c});
  endtask

  task automatic pulse_clr(input logic [2:0] m);
    clr = m;
    @(negedge clk);
    clr = '0;
  endtask

  function automatic int evts();
    return {28'd0, fs, ls, le, fe};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pix_valid = 1'b0; pix_data = '0; wsel = 2'd0;
    code_cfg = CFG_STD; unmask_cfg = 32'hFFFF_FFFF; fifo_full = 1'b0; clr = '0;
    repeat (3) @(negedge clk);
    chk("R13 reset events", evts(), 0);
    chk("R13 reset levels", {fv, lv, pv}, 0);
    chk("R13 reset pixel data", pd, 0);
    chk("R13 reset status", sts, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: one full frame with a line, in-line and out-of-line pixels
    for (int i = 0; i < NV; i++) begin
      put({6'h00, VEC[i][14:7]});
      chk("R6 R7 table strobes/levels", {evts(), fv, lv}, {28'd0, VEC[i][6:3], VEC[i][2:1]});
      chk("R1 R8 table pixel valid", pv, VEC[i][0]);
      if (VEC[i][0]) chk("R8 table pixel data", pd, {6'h00, VEC[i][14:7]});
    end
    chk("R10 frame done after table", sts, 3'b001);

    // R12: clearing another flag does not touch frame done; then clear it
    pulse_clr(3'b010);
    chk("R12 zero bits leave flag", sts, 3'b001);
    pulse_clr(3'b001);
    chk("R12 w1c frame done", sts, 3'b000);

    // R9: broken preamble
    put(14'h00FF);
    put(14'h0005);
    chk("R9 break error flag", sts, 3'b100);
    chk("R9 break no strobe", evts(), 0);
    pulse_clr(3'b100);
    chk("R12 w1c sync error", sts, 3'b000);

    // R9: unknown code, no wildcard
    put_code(8'h55);
    chk("R9 unmatched error", sts, 3'b100);
    chk("R9 unmatched no strobe", evts(), 0);
    pulse_clr(3'b100);

    // R4: wildcard frame finish
    code_cfg = {8'hFF, CFG_STD[23:0]};
    put_code(8'h55);
    chk("R4 wildcard frame end", evts(), 1);
    chk("R4 wildcard no error", sts, 3'b000);
    code_cfg = CFG_STD;

    // R2: masked compare, low nibble of line begin is don't-care
    unmask_cfg = 32'hFFFF_F0FF;
    put_code(8'h2F);
    chk("R2 masked line start", evts(), 4);
    chk("R7 line open", lv, 1);
    unmask_cfg = 32'hFFFF_FFFF;

    // R11: pixel while FIFO full
    fifo_full = 1'b1;
    put(14'h0123);
    fifo_full = 1'b0;
    chk("R11 overrun flag", sts, 3'b010);
    chk("R8 pixel data in line", pd, 14'h0123);
    put_code(8'h33);
    chk("R7 line closed", lv, 0);
    pulse_clr(3'b010);

    // R1 R2: 10-bit width, junk above active width, shifted code window
    wsel = 2'd1;
    put(14'h2BFF);
    put(14'h3000);
    put(14'h0000);
    put(14'h008B);
    chk("R2 shifted window line start", evts(), 4);
    chk("R1 junk upper bits no error", sts, 3'b000);
    chk("R1 code word not a pixel", pv, 0);
    wsel = 2'd0;
    put_code(8'h33);

    // R3: frame begin and line begin share a value
    code_cfg = {CFG_STD[31:16], 8'h11, 8'h11};
    put_code(8'h11);
    chk("R3 priority frame start only", evts(), 8);
    code_cfg = CFG_STD;

    // R5: inferred frame begin
    code_cfg = {CFG_STD[31:8], 8'hFF};
    unmask_cfg = 32'hFFFF_FFFF;
    put_code(8'h44);
    chk("R10 done on frame end in frame", sts, 3'b001);
    put_code(8'h22);
    chk("R5 first line start infers frame start", evts(), 12);
    chk("R5 frame opens", fv, 1);
    put_code(8'h33);
    put_code(8'h22);
    chk("R5 later line start only", evts(), 4);
    put_code(8'hFF);
    chk("R5 ff code not frame start", evts() & 8, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule